// File: doc/BRIEF.md
# Bank Burst Access Sequencer

This block drives one bank of a burst DRAM through a full access. It takes one request: bank ID, row, starting column, word count and direction. It then issues the commands in a fixed order. First comes an activate. Then a programmable number of stop cycles covers the activate-to-access delay. A read or write command follows, then the data beats, a stop placed so that exactly the last word follows it, and finally a precharge. The bank is closed after every burst, reads included, because opening a row destroys its contents in the array.

Each 32-bit word moves as two 16-bit halves. The block presents both halves of a beat side by side: `mem_adq_rise` carries the half for the rising edge and `mem_adq_fall` the half for the falling edge, and an external double-rate output cell combines them. Read halves arrive the same way from an external double-rate capture cell. The column offered with each beat counts up modulo 32, as the device does.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, so a request presented during a burst waits and its fields must stay stable until accepted. Write data is pulled: `wr_ready` rises in the cycle before each write beat, and because a burst cannot pause, the producer must hold `wr_valid` high whenever `wr_ready` is high. Read words leave on `rd_valid`/`rd_data` with no back-pressure.

Top module: `bank_burst_seq`

## Requirements
- R1: After reset `req_ready` is high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `mem_cmd` is ACTIVATE (4'h1), `mem_adq_rise` is {bank[7:0], row[7:0]}, `mem_adq_oe` is 1, and `req_ready` stays low until the cycle after the precharge.
- R2: After the activate cycle, `mem_cmd` carries STOP (4'h0) for exactly `cfg_trcd` cycles (0 to 3). The value is sampled when the request is accepted.
- R3: The access command follows the stop cycles. It is READ (4'h2) or WRITE (4'h3), with `mem_adq_rise` = {bank[7:0], 3'b000, col[4:0]}.
- R4: Beats run in consecutive cycles, starting in the cycle after the access command. `beat_valid` is high in each beat cycle. A request with `req_len` of 2 or more gives `req_len` beats. A `req_len` of 0 or 1 is run as 2 beats.
- R5: On beat k (counting from 0), `beat_col` equals (start column + k) mod 32, so the column wraps from 31 to 0.
- R6: During beats, `mem_cmd` is STOP on the second-to-last beat and NOP (4'hF) on every other beat.
- R7: In a write, each beat drives `mem_adq_rise` = word[15:0] and `mem_adq_fall` = word[31:16] with `mem_adq_oe` high. Beat k carries the k-th word taken from the write stream. Exactly as many handshakes happen as there are beats.
- R8: In a read, `mem_adq_oe` is low on every beat. One cycle after each beat, `rd_valid` is high and `rd_data` is {`mem_dq_fall_in`, `mem_dq_rise_in`} as seen during that beat. `rd_valid` is low at all other times.
- R9: The cycle after the last beat carries PRECHARGE (4'h4) with `mem_adq_rise` = {bank, 8'h00} and `done` high. In the cycle after that the block is idle: `mem_cmd` is NOP, `done` is low and `req_ready` is high.
- R10: While reset is held, `mem_cmd` is NOP, `mem_adq_oe`, `done`, `beat_valid` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 2 | Stop cycles between activate and access |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_bank | input | 8 | Bank ID |
| req_row | input | 8 | Row address |
| req_col | input | 5 | Starting column |
| req_len | input | 6 | Word count (0 and 1 run as 2) |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| mem_cmd | output | 4 | DRAM command code |
| mem_adq_rise | output | 16 | Address/data half for the rising edge |
| mem_adq_fall | output | 16 | Address/data half for the falling edge |
| mem_adq_oe | output | 1 | Controller drives the address/data bus |
| mem_dq_rise_in | input | 16 | Read half captured on the rising edge |
| mem_dq_fall_in | input | 16 | Read half captured on the falling edge |
| beat_valid | output | 1 | A data word is on the bus this cycle |
| beat_col | output | 5 | Column of the current beat |
| done | output | 1 | Precharge cycle, burst complete |

## Verification
Two pairs of functions can fall in the same cycle. A data beat shares its cycle with the STOP command. The precharge shares its cycle with the read capture of the final word. With a two-word request the STOP lands on the very first beat, right after the access command, and with `cfg_trcd` of 0 the access command follows the activate directly. Sweeping every delay, both directions and word counts from 0 to 40 over shifted start columns provokes both overlaps and every wrap position. Each cycle's command, bus halves, column and read word are compared against values computed from the request.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [3:0] {
    CMD_STOP = 4'h0,
    CMD_ACT  = 4'h1,
    CMD_RD   = 4'h2,
    CMD_WR   = 4'h3,
    CMD_PRE  = 4'h4,
    CMD_NOP  = 4'hF
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_CMD,
    ST_DATA,
    ST_PRE
  } state_e;
endpackage

// File: rtl/bbs_fsm.sv
module bbs_fsm
  import bbs_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int COL_W  = 5,
  parameter int LEN_W  = 6,
  parameter int TRCD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [HALF_W-1:0] req_bank,
  input  logic [HALF_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [TRCD_W-1:0] cfg_trcd,
  output state_e            st,
  output logic [HALF_W-1:0] lat_bank,
  output logic [HALF_W-1:0] lat_row,
  output logic [COL_W-1:0]  cur_col,
  output logic              lat_write,
  output logic              stop_now,
  output logic              wr_pull,
  output logic              req_ready
);
  localparam logic [LEN_W-1:0]  MIN_LEN = LEN_W'(2);
  localparam logic [LEN_W-1:0]  ONE_L   = LEN_W'(1);
  localparam logic [TRCD_W-1:0] ONE_T   = TRCD_W'(1);

  logic [LEN_W-1:0]  eff_len;
  logic [LEN_W-1:0]  wcnt;
  logic [TRCD_W-1:0] trcd_q;
  logic [TRCD_W-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lat_bank  <= '0;
      lat_row   <= '0;
      cur_col   <= '0;
      lat_write <= 1'b0;
      eff_len   <= MIN_LEN;
      wcnt      <= '0;
      trcd_q    <= '0;
      gcnt      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          lat_bank  <= req_bank;
          lat_row   <= req_row;
          cur_col   <= req_col;
          lat_write <= req_write;
          eff_len   <= (req_len < MIN_LEN) ? MIN_LEN : req_len;
          trcd_q    <= cfg_trcd;
          st        <= ST_ACT;
        end
        ST_ACT: begin
          gcnt <= trcd_q;
          st   <= (trcd_q == '0) ? ST_CMD : ST_GAP;
        end
        ST_GAP: begin
          gcnt <= gcnt - ONE_T;
          if (gcnt == ONE_T) st <= ST_CMD;
        end
        ST_CMD: begin
          wcnt <= ONE_L;
          st   <= ST_DATA;
        end
        ST_DATA: begin
          cur_col <= cur_col + COL_W'(1);
          wcnt    <= wcnt + ONE_L;
          if (wcnt == eff_len) st <= ST_PRE;
        end
        ST_PRE:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign stop_now  = (st == ST_DATA) && (wcnt == eff_len - ONE_L);
  assign wr_pull   = lat_write &&
                     ((st == ST_CMD) || ((st == ST_DATA) && (wcnt != eff_len)));
endmodule

// File: rtl/bbs_bus_fmt.sv
module bbs_bus_fmt
  import bbs_pkg::*;
#(
  parameter int ADQ_W = 16,
  parameter int COL_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  state_e               st,
  input  logic                 stop_now,
  input  logic                 lat_write,
  input  logic [ADQ_W/2-1:0]   lat_bank,
  input  logic [ADQ_W/2-1:0]   lat_row,
  input  logic [COL_W-1:0]     cur_col,
  input  logic                 wr_take,
  input  logic [2*ADQ_W-1:0]   wr_data,
  output logic [3:0]           mem_cmd,
  output logic [ADQ_W-1:0]     adq_rise,
  output logic [ADQ_W-1:0]     adq_fall,
  output logic                 adq_oe,
  output logic                 beat_valid
);
  localparam int HALF_W = ADQ_W / 2;
  localparam int PAD_W  = HALF_W - COL_W;

  logic [2*ADQ_W-1:0] wbuf;
  logic [ADQ_W-1:0]   addr;

  always_ff @(posedge clk) begin
    if (!rst_n)       wbuf <= '0;
    else if (wr_take) wbuf <= wr_data;
  end

  always_comb begin
    mem_cmd    = CMD_NOP;
    addr       = '0;
    adq_oe     = 1'b0;
    beat_valid = 1'b0;
    adq_rise   = '0;
    adq_fall   = '0;
    case (st)
      ST_ACT: begin
        mem_cmd = CMD_ACT;
        addr    = {lat_bank, lat_row};
        adq_oe  = 1'b1;
      end
      ST_GAP: begin
        mem_cmd = CMD_STOP;
        adq_oe  = 1'b1;
      end
      ST_CMD: begin
        mem_cmd = lat_write ? CMD_WR : CMD_RD;
        addr    = {lat_bank, {PAD_W{1'b0}}, cur_col};
        adq_oe  = 1'b1;
      end
      ST_DATA: begin
        mem_cmd    = stop_now ? CMD_STOP : CMD_NOP;
        beat_valid = 1'b1;
        adq_oe     = lat_write;
      end
      ST_PRE: begin
        mem_cmd = CMD_PRE;
        addr    = {lat_bank, {HALF_W{1'b0}}};
        adq_oe  = 1'b1;
      end
      default: mem_cmd = CMD_NOP;
    endcase
    if (st == ST_DATA) begin
      if (lat_write) begin
        adq_rise = wbuf[ADQ_W-1:0];
        adq_fall = wbuf[2*ADQ_W-1:ADQ_W];
      end
    end else begin
      adq_rise = addr;
      adq_fall = addr;
    end
  end
endmodule

// File: rtl/bbs_rd_cap.sv
module bbs_rd_cap #(
  parameter int ADQ_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ADQ_W-1:0]   dq_rise,
  input  logic [ADQ_W-1:0]   dq_fall,
  output logic               rd_valid,
  output logic [2*ADQ_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= {dq_fall, dq_rise};
    end
  end
endmodule

// File: rtl/bank_burst_seq.sv
module bank_burst_seq
  import bbs_pkg::*;
#(
  parameter int ADQ_W  = 16,
  parameter int COL_W  = 5,
  parameter int LEN_W  = 6,
  parameter int TRCD_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TRCD_W-1:0]    cfg_trcd,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADQ_W/2-1:0]   req_bank,
  input  logic [ADQ_W/2-1:0]   req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_write,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [2*ADQ_W-1:0]   wr_data,
  output logic                 rd_valid,
  output logic [2*ADQ_W-1:0]   rd_data,
  output logic [3:0]           mem_cmd,
  output logic [ADQ_W-1:0]     mem_adq_rise,
  output logic [ADQ_W-1:0]     mem_adq_fall,
  output logic                 mem_adq_oe,
  input  logic [ADQ_W-1:0]     mem_dq_rise_in,
  input  logic [ADQ_W-1:0]     mem_dq_fall_in,
  output logic                 beat_valid,
  output logic [COL_W-1:0]     beat_col,
  output logic                 done
);
  localparam int HALF_W = ADQ_W / 2;

  state_e            st;
  logic [HALF_W-1:0] lat_bank;
  logic [HALF_W-1:0] lat_row;
  logic [COL_W-1:0]  cur_col;
  logic              lat_write;
  logic              stop_now;
  logic              wr_pull;

  bbs_fsm #(
    .HALF_W(HALF_W), .COL_W(COL_W), .LEN_W(LEN_W), .TRCD_W(TRCD_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_len(req_len), .req_write(req_write),
    .cfg_trcd(cfg_trcd),
    .st(st), .lat_bank(lat_bank), .lat_row(lat_row), .cur_col(cur_col),
    .lat_write(lat_write), .stop_now(stop_now), .wr_pull(wr_pull),
    .req_ready(req_ready)
  );

  bbs_bus_fmt #(.ADQ_W(ADQ_W), .COL_W(COL_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .st(st), .stop_now(stop_now),
    .lat_write(lat_write), .lat_bank(lat_bank), .lat_row(lat_row),
    .cur_col(cur_col), .wr_take(wr_pull && wr_valid), .wr_data(wr_data),
    .mem_cmd(mem_cmd), .adq_rise(mem_adq_rise), .adq_fall(mem_adq_fall),
    .adq_oe(mem_adq_oe), .beat_valid(beat_valid)
  );

  bbs_rd_cap #(.ADQ_W(ADQ_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .capture((st == ST_DATA) && !lat_write),
    .dq_rise(mem_dq_rise_in), .dq_fall(mem_dq_fall_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign wr_ready = wr_pull;
  assign beat_col = cur_col;
  assign done     = (st == ST_PRE);
endmodule

// File: rtl/bank_burst_seq_chk.sv
module bank_burst_seq_chk
  import bbs_pkg::*;
#(
  parameter int ADQ_W = 16,
  parameter int COL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADQ_W/2-1:0] req_bank,
  input logic [ADQ_W/2-1:0] req_row,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               rd_valid,
  input logic [3:0]         mem_cmd,
  input logic [ADQ_W-1:0]   mem_adq_rise,
  input logic               mem_adq_oe,
  input logic               beat_valid,
  input logic [COL_W-1:0]   beat_col,
  input logic               done
);
  p_accept_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_cmd == CMD_ACT) && !req_ready);

  p_act_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_adq_rise == {$past(req_bank), $past(req_row)});

  p_col_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> beat_col == $past(beat_col) + COL_W'(1));

  p_stop_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && mem_cmd == CMD_STOP) |=> beat_valid && (mem_cmd == CMD_NOP) ##1 (mem_cmd == CMD_PRE));

  p_wr_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_valid);

  p_read_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !mem_adq_oe) |=> rd_valid);

  p_read_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(beat_valid && !mem_adq_oe));

  p_pre_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cmd == CMD_PRE) && !beat_valid);

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && (mem_cmd == CMD_NOP) && !done);
endmodule

bind bank_burst_seq bank_burst_seq_chk #(.ADQ_W(ADQ_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_row(req_row), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .mem_cmd(mem_cmd),
  .mem_adq_rise(mem_adq_rise), .mem_adq_oe(mem_adq_oe),
  .beat_valid(beat_valid), .beat_col(beat_col), .done(done)
);

// File: tb/bank_burst_seq_test.sv
module bank_burst_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_trcd = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bank = '0;
  logic [7:0]  req_row = '0;
  logic [4:0]  req_col = '0;
  logic [5:0]  req_len = '0;
  logic        req_write = 1'b0;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [31:0] wr_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  mem_cmd;
  logic [15:0] mem_adq_rise;
  logic [15:0] mem_adq_fall;
  logic        mem_adq_oe;
  logic [15:0] mem_dq_rise_in = '0;
  logic [15:0] mem_dq_fall_in = '0;
  logic        beat_valid;
  logic [4:0]  beat_col;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  int wr_hs = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .req_write(req_write), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cmd(mem_cmd), .mem_adq_rise(mem_adq_rise),
    .mem_adq_fall(mem_adq_fall), .mem_adq_oe(mem_adq_oe),
    .mem_dq_rise_in(mem_dq_rise_in), .mem_dq_fall_in(mem_dq_fall_in),
    .beat_valid(beat_valid), .beat_col(beat_col), .done(done)
  );

  function automatic logic [31:0] wpat(int n);
    return 32'hC0DE0000 ^ (32'(n) * 32'h00051237);
  endfunction

  function automatic logic [31:0] rpat(int k, logic [7:0] b);
    return 32'h5A3C0000 + 32'(k) * 32'h00030011 + {b, 24'h0};
  endfunction

  assign wr_data = wpat(wr_hs);

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) wr_hs <= wr_hs + 1;

  task automatic check(string rid, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rid, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_one(int trcd, bit wr, int len, logic [7:0] bank,
                         logic [7:0] row, logic [4:0] col, bit hold);
    int eff  = (len < 2) ? 2 : len;
    int base = wr_hs;
    check("R1", "ready idle", 32'(req_ready), 1);
    cfg_trcd  = 2'(trcd);
    req_bank  = bank;
    req_row   = row;
    req_col   = col;
    req_len   = 6'(len);
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    // a second request held on the inputs must wait while busy
    req_valid = hold;
    req_bank  = ~bank;
    check("R1", "act cmd", 32'(mem_cmd), 32'h1);
    check("R1", "act adq", 32'(mem_adq_rise), {16'h0, bank, row});
    check("R1", "act oe", 32'(mem_adq_oe), 1);
    check("R1", "busy ready", 32'(req_ready), 0);
    for (int g = 1; g <= trcd; g++) begin
      @(negedge clk);
      check("R2", "gap stop", 32'(mem_cmd), 32'h0);
    end
    @(negedge clk);
    check("R3", "access cmd", 32'(mem_cmd), wr ? 32'h3 : 32'h2);
    check("R3", "access adq", 32'(mem_adq_rise), {16'h0, bank, 3'b000, col});
    for (int k = 0; k < eff; k++) begin
      @(negedge clk);
      if (!wr) begin
        mem_dq_rise_in = rpat(k, bank)[15:0];
        mem_dq_fall_in = rpat(k, bank)[31:16];
      end
      check("R4", "beat valid", 32'(beat_valid), 1);
      check("R5", "beat col", 32'(beat_col), 32'((int'(col) + k) % 32));
      check("R6", "beat cmd", 32'(mem_cmd), (k == eff - 2) ? 32'h0 : 32'hF);
      check("R1", "busy ready", 32'(req_ready), 0);
      if (wr) begin
        check("R7", "wr rise", 32'(mem_adq_rise), {16'h0, wpat(base + k)[15:0]});
        check("R7", "wr fall", 32'(mem_adq_fall), {16'h0, wpat(base + k)[31:16]});
        check("R7", "wr oe", 32'(mem_adq_oe), 1);
      end else begin
        check("R8", "rd oe", 32'(mem_adq_oe), 0);
        if (k == 0) check("R8", "rd valid first", 32'(rd_valid), 0);
        else begin
          check("R8", "rd valid", 32'(rd_valid), 1);
          check("R8", "rd data", rd_data, rpat(k - 1, bank));
        end
      end
    end
    @(negedge clk);
    check("R9", "pre cmd", 32'(mem_cmd), 32'h4);
    check("R9", "pre adq", 32'(mem_adq_rise), {16'h0, bank, 8'h00});
    check("R9", "done", 32'(done), 1);
    check("R4", "no beat at pre", 32'(beat_valid), 0);
    if (wr) check("R7", "handshakes", 32'(wr_hs - base), 32'(eff));
    else begin
      check("R8", "rd valid last", 32'(rd_valid), 1);
      check("R8", "rd data last", rd_data, rpat(eff - 1, bank));
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "idle cmd", 32'(mem_cmd), 32'hF);
    check("R9", "done low", 32'(done), 0);
    check("R9", "ready back", 32'(req_ready), 1);
    check("R8", "rd valid idle", 32'(rd_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset cmd", 32'(mem_cmd), 32'hF);
    check("R10", "reset oe", 32'(mem_adq_oe), 0);
    check("R10", "reset ready", 32'(req_ready), 1);
    check("R10", "reset done", 32'(done), 0);
    check("R10", "reset beat", 32'(beat_valid), 0);
    check("R10", "reset rd", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 4; t++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l <= 40; l++)
          run_one(t, w[0], l, 8'(l * 5 + t * 64 + w), 8'(255 - l),
                  5'((l * 7 + t * 3 + w * 13) % 32), (l % 3) == 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule